// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours (24-hour only), day of month, 1-based month and a two-digit year that stands for 2000 to 2099. A 32.768 kHz tick arrives as a one-cycle enable on the system clock, and a prescaler divides it down to one-second steps. Each step carries through the fields with month lengths and leap years applied, so software reads a calendar that is always valid.

A byte-wide register port gives access to the six time fields, six alarm fields, a control register with the run bit, a status register and an interrupt-enable register. The alarm fires only when all six time fields equal the six alarm fields just after a step; no field can be masked. A busy flag marks the final tick period before each step, so software knows when the counters are about to change. Status flags record second, minute, hour and day roll events and the alarm. They are cleared by writing ones. An interrupt output combines the latched alarm and the one-second pulse, each gated by its own enable bit.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00. Control, status and interrupt-enable read 0x00, and `irq`, `secEvent` and `alarmEvent` are 0.
- R2: Control register (offset 0x40) bit 0 is the run bit. While it is 0 the prescaler and all time fields hold their values. Status bit 1 reads the run bit.
- R3: While running, the seconds field advances once for every 2^PRESCALE_BITS cycles with `tickEn` high. `secEvent` is high for exactly the one clock cycle that follows the cycle in which the step happens.
- R4: Status (offset 0x44) bit 0 (busy) is 1 exactly while running with the prescaler at its final count, which is the tick period just before a step. It is 0 again once the step has happened.
- R5: Seconds and minutes go from 0x59 to 0x00 and carry to the next field. Hours go from 0x23 to 0x00 and carry into the day.
- R6: The day goes back to 0x01 and the month advances after day 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after 0x30 in months 04, 06, 09 and 11. The month goes from 0x12 to 0x01 and carries into the year, and the year goes from 0x99 to 0x00.
- R7: In February the day goes back after 0x29 when the year is divisible by 4 (including 00 and 12), and after 0x28 otherwise.
- R8: Alarm fields sit at offsets 0x20 (sec), 0x24, 0x28, 0x2C, 0x30 and 0x34 (year). If all six equal the time in the cycle after a step, then in the next cycle status bit 6 is set and `alarmEvent` pulses for one cycle. A mismatch in any single field, the year included, gives no alarm.
- R9: Status bit 2 is set on every step. Bit 3 is set when the seconds wrap, bit 4 when the minutes wrap and bit 5 when the hours wrap.
- R10: Writing 1 to status bits 2 to 6 clears them, and writing 0 leaves them unchanged. Bits 0 and 1 ignore writes.
- R11: `irq` = (status bit 6 AND interrupt-enable bit 3) OR (`secEvent` AND interrupt-enable bit 2). Interrupt-enable is at offset 0x48.
- R12: Control bit 3 (12-hour select) always reads 0, so the clock stays in 24-hour mode. Only bits 2 and 3 of interrupt-enable are stored. All other control and enable bits read 0.
- R13: Time fields at offsets 0x00 (sec), 0x04 (min), 0x08 (hour), 0x0C (day), 0x10 (month) and 0x14 (year), and the alarm fields, load the written byte and read it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per 32.768 kHz period |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| secEvent | output | 1 | One-cycle pulse after each seconds step |
| alarmEvent | output | 1 | One-cycle pulse when the alarm matches |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with PRESCALE_BITS = 3, so one second takes eight tick enables. Holding `tickEn` high then produces a step every eight clock cycles. This puts the busy window, the carry chain from seconds up to the year, every month length and the leap-year cases within a few dozen cycles each. The busy flag is tested by stopping one tick short of a step. Rollovers are tested by preloading the time one second before each boundary.

// File: rtl/calendar_pkg.sv
package calendar_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_W    = 8;

  // field index: 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year
  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] calTime_t;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrTime;
    logic [NUM_FIELDS-1:0] wrAlarm;
    logic [FIELD_W-1:0]    data;
  } calStrobe_t;

  typedef struct packed {
    logic minRoll;
    logic hourRoll;
    logic dayRoll;
  } calRoll_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [7:0] yr);
    logic [1:0] rem;
    rem = {yr[4], 1'b0} + yr[1:0];
    return rem == 2'd0;
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] fieldTop(input int idx, input logic [7:0] dayTop);
    case (idx)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      3:       return dayTop;
      4:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] fieldFloor(input int idx);
    return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  output calTime_t   curTime,
  output calTime_t   alarmTime,
  output logic       alarmMatch,
  output calRoll_t   rolls
);
  logic [NUM_FIELDS:0]   carry;
  logic [NUM_FIELDS-1:0] atTop;
  calTime_t              nxtTime;
  logic [7:0]            dayTop;

  always_comb begin
    dayTop   = lastDay(curTime[4], curTime[5]);
    carry[0] = 1'b1;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      atTop[i]   = curTime[i] == fieldTop(i, dayTop);
      carry[i+1] = carry[i] && atTop[i];
      if (!carry[i])     nxtTime[i] = curTime[i];
      else if (atTop[i]) nxtTime[i] = fieldFloor(i);
      else               nxtTime[i] = bcdInc(curTime[i]);
    end
  end

  assign rolls.minRoll  = carry[1];
  assign rolls.hourRoll = carry[2];
  assign rolls.dayRoll  = carry[3];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
    always_ff @(posedge clk) begin
      if (!rstN) begin
        curTime[g]   <= fieldFloor(g);
        alarmTime[g] <= '0;
      end else begin
        if (strobe.wrTime[g])      curTime[g] <= strobe.data;
        else if (strobe.advance)   curTime[g] <= nxtTime[g];
        if (strobe.wrAlarm[g])     alarmTime[g] <= strobe.data;
      end
    end
  end

  assign alarmMatch = curTime == alarmTime;
endmodule

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
#(
  parameter int PRESCALE_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  calTime_t   curTime,
  input  calTime_t   alarmTime,
  input  logic       alarmMatch,
  input  calRoll_t   rolls,
  output calStrobe_t strobe,
  output logic [7:0] rdData,
  output logic       secEvent,
  output logic       alarmEvent,
  output logic       irq,
  output logic       busy,
  output logic       runBit,
  output logic       alarmSt
);
  localparam logic [PRESCALE_BITS-1:0] PRE_MAX = '1;
  localparam logic [7:0] CTRL_OFS = 8'h40;
  localparam logic [7:0] STAT_OFS = 8'h44;
  localparam logic [7:0] IEN_OFS  = 8'h48;

  logic [PRESCALE_BITS-1:0] preCnt;
  logic       advance, justAdv, alarmHit;
  logic       secSt, minSt, hourSt, daySt;
  logic       alarmIen, timerIen;
  logic [2:0] fieldIdx;
  logic       isTime, isAlarm, wrStat;

  assign fieldIdx = addr[4:2];
  assign isTime   = addr[7:5] == 3'b000 && addr[1:0] == 2'b00 && fieldIdx < 3'd6;
  assign isAlarm  = addr[7:5] == 3'b001 && addr[1:0] == 2'b00 && fieldIdx < 3'd6;
  assign wrStat   = wrEn && addr == STAT_OFS;

  assign busy    = runBit && preCnt == PRE_MAX;
  assign advance = busy && tickEn;

  assign strobe.advance = advance;
  assign strobe.data    = wrData;
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gStrobe
    assign strobe.wrTime[g]  = wrEn && isTime  && fieldIdx == 3'(g);
    assign strobe.wrAlarm[g] = wrEn && isAlarm && fieldIdx == 3'(g);
  end

  assign alarmHit = justAdv && alarmMatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt     <= '0;
      runBit     <= 1'b0;
      alarmIen   <= 1'b0;
      timerIen   <= 1'b0;
      justAdv    <= 1'b0;
      secEvent   <= 1'b0;
      alarmEvent <= 1'b0;
      secSt      <= 1'b0;
      minSt      <= 1'b0;
      hourSt     <= 1'b0;
      daySt      <= 1'b0;
      alarmSt    <= 1'b0;
    end else begin
      if (runBit && tickEn) preCnt <= preCnt + 1'b1;
      if (wrEn && addr == CTRL_OFS) runBit <= wrData[0];
      if (wrEn && addr == IEN_OFS) begin
        alarmIen <= wrData[3];
        timerIen <= wrData[2];
      end
      justAdv    <= advance;
      secEvent   <= advance;
      alarmEvent <= alarmHit;
      secSt   <= advance                    || (secSt   && !(wrStat && wrData[2]));
      minSt   <= (advance && rolls.minRoll)  || (minSt   && !(wrStat && wrData[3]));
      hourSt  <= (advance && rolls.hourRoll) || (hourSt  && !(wrStat && wrData[4]));
      daySt   <= (advance && rolls.dayRoll)  || (daySt   && !(wrStat && wrData[5]));
      alarmSt <= alarmHit                   || (alarmSt && !(wrStat && wrData[6]));
    end
  end

  assign irq = (alarmSt && alarmIen) || (secEvent && timerIen);

  always_comb begin
    rdData = '0;
    if (isTime)       rdData = curTime[fieldIdx];
    else if (isAlarm) rdData = alarmTime[fieldIdx];
    else begin
      case (addr)
        CTRL_OFS: rdData = {7'b0, runBit};
        STAT_OFS: rdData = {1'b0, alarmSt, daySt, hourSt, minSt, secSt, runBit, busy};
        IEN_OFS:  rdData = {4'b0, alarmIen, timerIen, 2'b0};
        default:  rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import calendar_pkg::*;
#(
  parameter int PRESCALE_BITS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       secEvent,
  output logic       alarmEvent,
  output logic       irq
);
  calStrobe_t strobe;
  calTime_t   curTime, alarmTime;
  calRoll_t   rolls;
  logic       alarmMatch, busy, runBit, alarmSt;

  calendar_ctrl #(.PRESCALE_BITS(PRESCALE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .curTime(curTime), .alarmTime(alarmTime),
    .alarmMatch(alarmMatch), .rolls(rolls), .strobe(strobe), .rdData(rdData),
    .secEvent(secEvent), .alarmEvent(alarmEvent), .irq(irq), .busy(busy),
    .runBit(runBit), .alarmSt(alarmSt)
  );

  calendar_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curTime(curTime),
    .alarmTime(alarmTime), .alarmMatch(alarmMatch), .rolls(rolls)
  );
endmodule

// File: rtl/calendar_checker.sv
module calendar_checker
  import calendar_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     wrEn,
  input logic     secEvent,
  input logic     alarmEvent,
  input logic     busy,
  input logic     runBit,
  input logic     alarmSt,
  input calTime_t curTime
);
  assert_sec_bcd_R5: assert property (@(posedge clk) disable iff (!rstN)
    curTime[0] <= 8'h59 && curTime[0][3:0] <= 4'd9);

  assert_hour_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    curTime[2] <= 8'h23);

  assert_day_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    curTime[3] != 8'h00 && curTime[3] <= 8'h31);

  assert_event_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    secEvent |-> $past(busy));

  assert_frozen_when_stopped_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !$past(runBit) && !$past(wrEn)) |-> $stable(curTime));

  assert_alarm_latched_R8: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvent |-> alarmSt);
endmodule

bind bcd_calendar_clock calendar_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .secEvent(secEvent),
  .alarmEvent(alarmEvent), .busy(busy), .runBit(runBit),
  .alarmSt(alarmSt), .curTime(curTime)
);

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       secEvent, alarmEvent, irq;
  int         nChecks = 0;
  int         nFails = 0;
  logic [7:0] v;

  bcd_calendar_clock #(.PRESCALE_BITS(3)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .secEvent(secEvent),
    .alarmEvent(alarmEvent), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #2;
    d = rdData;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  task automatic expectTime(input string req, input logic [7:0] y, mo, d, h, mi, s);
    logic [7:0] r;
    rd(8'h00, r); chk({req, " sec"}, r, s);
    rd(8'h04, r); chk({req, " min"}, r, mi);
    rd(8'h08, r); chk({req, " hour"}, r, h);
    rd(8'h0C, r); chk({req, " day"}, r, d);
    rd(8'h10, r); chk({req, " month"}, r, mo);
    rd(8'h14, r); chk({req, " year"}, r, y);
  endtask

  task automatic testReset();
    expectTime("R1 reset", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h00);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 secEvent", {7'b0, secEvent}, 8'h00);
    chk("R1 alarmEvent", {7'b0, alarmEvent}, 8'h00);
  endtask

  task automatic testStopped();
    setTime(8'h25, 8'h03, 8'h10, 8'h08, 8'h15, 8'h42);
    expectTime("R13 readback", 8'h25, 8'h03, 8'h10, 8'h08, 8'h15, 8'h42);
    tick(16);
    rd(8'h00, v); chk("R2 frozen sec", v, 8'h42);
    chk("R2 no secEvent", {7'b0, secEvent}, 8'h00);
    rd(8'h44, v); chk("R2 status while stopped", v, 8'h00);
  endtask

  task automatic testRunCtrl();
    wr(8'h40, 8'h09);
    rd(8'h40, v); chk("R12 ctrl 24h forced", v, 8'h01);
    rd(8'h44, v); chk("R2 run reflected", v, 8'h02);
    wr(8'h48, 8'hFF);
    rd(8'h48, v); chk("R12 ien stored bits", v, 8'h0C);
    wr(8'h48, 8'h00);
  endtask

  task automatic testBusyStep();
    tick(7);
    rd(8'h44, v); chk("R4 busy before step", v & 8'h01, 8'h01);
    rd(8'h00, v); chk("R3 no step yet", v, 8'h42);
    tick(1);
    chk("R3 secEvent pulse", {7'b0, secEvent}, 8'h01);
    rd(8'h00, v); chk("R3 seconds step", v, 8'h43);
    rd(8'h44, v); chk("R4 busy cleared R9 sec flag", v, 8'h06);
    @(negedge clk);
    chk("R3 secEvent one cycle", {7'b0, secEvent}, 8'h00);
  endtask

  task automatic testClear();
    wr(8'h44, 8'h03);
    rd(8'h44, v); chk("R10 write 0 keeps, ro bits", v, 8'h06);
    wr(8'h44, 8'h04);
    rd(8'h44, v); chk("R10 w1c sec flag", v, 8'h02);
  endtask

  task automatic testFullRoll();
    setTime(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    tick(8);
    expectTime("R5 R6 full rollover", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rd(8'h44, v); chk("R9 roll flags", v, 8'h3E);
    wr(8'h44, 8'h7C);
    setTime(8'h25, 8'h05, 8'h07, 8'h12, 8'h34, 8'h59);
    tick(8);
    expectTime("R5 minute carry", 8'h25, 8'h05, 8'h07, 8'h12, 8'h35, 8'h00);
    rd(8'h44, v); chk("R9 minute flag only", v, 8'h0E);
    wr(8'h44, 8'h7C);
  endtask

  task automatic monthCase(input string req, input logic [7:0] y, mo, d,
                           input logic [7:0] expMo, expD);
    logic [7:0] r;
    setTime(y, mo, d, 8'h23, 8'h59, 8'h59);
    tick(8);
    rd(8'h0C, r); chk({req, " day"}, r, expD);
    rd(8'h10, r); chk({req, " month"}, r, expMo);
  endtask

  task automatic testMonths();
    monthCase("R6 30-day month", 8'h25, 8'h04, 8'h30, 8'h05, 8'h01);
    monthCase("R6 31-day month no roll at 30", 8'h25, 8'h08, 8'h30, 8'h08, 8'h31);
    monthCase("R6 31-day month", 8'h25, 8'h07, 8'h31, 8'h08, 8'h01);
    monthCase("R7 common Feb", 8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
    monthCase("R7 leap 24 Feb28", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
    monthCase("R7 leap 24 Feb29", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
    monthCase("R7 leap 00", 8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
    monthCase("R7 leap 12", 8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
    wr(8'h44, 8'h7C);
  endtask

  task automatic testAlarm();
    setTime(8'h25, 8'h06, 8'h15, 8'h10, 8'h20, 8'h30);
    wr(8'h20, 8'h31); wr(8'h24, 8'h20); wr(8'h28, 8'h10);
    wr(8'h2C, 8'h15); wr(8'h30, 8'h06); wr(8'h34, 8'h26);
    rd(8'h34, v); chk("R13 alarm readback", v, 8'h26);
    tick(8);
    @(negedge clk);
    chk("R8 year mismatch no event", {7'b0, alarmEvent}, 8'h00);
    rd(8'h44, v); chk("R8 year mismatch no flag", v & 8'h40, 8'h00);
    wr(8'h34, 8'h25);
    wr(8'h00, 8'h30);
    tick(8);
    @(negedge clk);
    chk("R8 alarm event", {7'b0, alarmEvent}, 8'h01);
    rd(8'h44, v); chk("R8 alarm flag", v & 8'h40, 8'h40);
    @(negedge clk);
    chk("R8 event one cycle", {7'b0, alarmEvent}, 8'h00);
  endtask

  task automatic testIrq();
    chk("R11 irq off without enable", {7'b0, irq}, 8'h00);
    wr(8'h48, 8'h08);
    #2; chk("R11 alarm irq", {7'b0, irq}, 8'h01);
    wr(8'h44, 8'h40);
    #2; chk("R11 irq drops after clear", {7'b0, irq}, 8'h00);
    rd(8'h44, v); chk("R10 alarm flag cleared", v & 8'h40, 8'h00);
    wr(8'h48, 8'h04);
    tick(8);
    chk("R11 timer irq", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R11 timer irq pulse ends", {7'b0, irq}, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStopped();
    testRunCtrl();
    testBusyStep();
    testClear();
    testFullRoll();
    testMonths();
    testAlarm();
    testIrq();
    summary();
  end
endmodule